// File: doc/BRIEF.md
# Daisy-Chain Phase Token Sequencer

This block is the controller end of a ring of phase units. It produces a free-running system clock, which every phase unit receives, and a phase token. The token leaves the controller on its token output, is handed from unit to unit on each falling edge of the system clock, and comes back on the controller's return input. After reset the block launches a single token and counts falling edges until it returns. That count is the number of phases in the ring.

Once the count is known and legal, the block relaunches the token every N system clock periods, where N is the learned count. Each phase therefore switches once every N clock periods, so the system clock rate is N times the per-phase switching rate. The return input is watched on every falling edge. A token that is missing when one is due, or present when none is due, is treated as a broken ring. A too-short, too-long or missing first return is also a ring fault.

A companion single-phase stage (`pstk_phase_stage`) models what each unit does with the token. It captures its token input on every falling edge of the system clock and drives it on to the next unit.

The whole block runs on one fast core clock, and the system clock is derived from it. In this brief a "fall" means a core cycle in which the system clock has just gone low. Tokens are captured at the end of that cycle.

Top module: `pstk_token_seq`

## Requirements
- R1: While the synchronous reset `srst` is high, and in the first cycle after it falls, `phase_cnt_o`=0, `ring_fault_o`=0, `ready_o`=0 and `token_o`=0. Releasing reset always restarts detection from the beginning.
- R2: `sysclk_o` is high for SYS_DIV/2 core cycles and low for SYS_DIV/2 core cycles (SYS_DIV=4 by default). It runs without interruption in every state, including fault.
- R3: The token is launched at fall #1 after reset: `token_o` rises after that fall and stays high for exactly one system clock period, falling after fall #2.
- R4: If the return input is first seen high at fall #(N+2), with N in 1..MAX_PHASES (8), then in the next cycle `ready_o`=1 and `phase_cnt_o`=N. Before that `ready_o` is 0.
- R5: If the first return gives a count of 0 or a count above MAX_PHASES, `ring_fault_o` rises after that fall. `ready_o` stays 0 and `phase_cnt_o` stays 0.
- R6: If no token has returned by fall #(RETURN_LIMIT+1) (fall #17 by default), `ring_fault_o` rises exactly after that fall.
- R7: While ready, `token_o` is high for exactly one system clock period out of every N. Over any 4N periods it is therefore high for 4*SYS_DIV core cycles.
- R8: While ready, a missing token on a due fall or an extra token on any other fall sets `ring_fault_o` and clears `ready_o`.
- R9: `ring_fault_o` is sticky until reset, and `token_o` stays low while the fault is set.
- R10: The phase stage output, in the cycle after a fall, equals the stage input as it was during that fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| srst | input | 1 | Synchronous active-high reset; restarts detection |
| ring_ret_i | input | 1 | Token returning from the last phase unit |
| sysclk_o | output | 1 | System clock to all phase units |
| token_o | output | 1 | Token to the first phase unit |
| phase_cnt_o | output | 4 | Learned number of phases (0 until learned) |
| ring_fault_o | output | 1 | Sticky ring fault |
| ready_o | output | 1 | Phase count valid and ring healthy |

## Verification
The hardest case to reach is a spurious token during steady operation that lands on a fall where no return is due. A token injected on a due fall would simply merge with the real one. The bench builds a ten-stage ring from the companion stage and selects its length from 0 to 10, which sweeps every legal and illegal count.

To reach the spurious-token case, it forces the return high for one full system clock period starting the cycle after ready rises. The first fall after detection is never a due fall for a ring of four. A broken ring is produced the same way, either from reset, which exercises the exact timeout fall, or in the middle of steady operation.

// File: rtl/pstk_pkg.sv
package pstk_pkg;

    typedef enum logic [1:0] {
        ST_LAUNCH,
        ST_MEASURE,
        ST_RUN,
        ST_FAULT
    } seq_state_e;

    // System clock level plus a strobe for the first low cycle
    typedef struct packed {
        logic lvl;
        logic fall;
    } sysclk_s;

    // Steady-state cadence results for one fall
    typedef struct packed {
        logic launch;
        logic miss;
        logic extra;
    } cadence_s;

    function automatic logic count_ok(input int cnt, input int max_ph);
        return (cnt >= 1) && (cnt <= max_ph);
    endfunction

endpackage

// File: rtl/pstk_phase_stage.sv
// Companion model of one unit in the ring: passes the token on at each fall
module pstk_phase_stage (
    input  logic clk,
    input  logic srst,
    input  logic sysclk_i,
    input  logic token_i,
    output logic token_o
);
    logic clk_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            clk_q   <= 1'b0;
            token_o <= 1'b0;
        end else begin
            clk_q <= sysclk_i;
            if (clk_q && !sysclk_i) begin
                token_o <= token_i;
            end
        end
    end
endmodule

// File: rtl/pstk_sysclk.sv
module pstk_sysclk
    import pstk_pkg::*;
#(
    parameter int SYS_DIV = 4
) (
    input  logic    clk,
    input  logic    srst,
    output sysclk_s sc
);
    localparam int HALF = SYS_DIV / 2;
    localparam int DW   = (SYS_DIV > 2) ? $clog2(SYS_DIV) : 1;

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (srst || cnt == DW'(SYS_DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        sc.lvl  = (cnt < DW'(HALF));
        sc.fall = (cnt == DW'(HALF));
    end
endmodule

// File: rtl/pstk_cadence.sv
module pstk_cadence
    import pstk_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          fall,
    input  logic          restart,
    input  logic          active,
    input  logic [PW-1:0] period,
    input  logic          ret_i,
    output cadence_s      cad
);
    logic [PW-1:0] slot;
    logic          armed;
    logic          wrap;
    logic          due;

    assign wrap = (slot == period - 1'b1);
    assign due  = armed && (slot == '0);

    always_ff @(posedge clk) begin
        if (srst || restart) begin
            slot  <= '0;
            armed <= 1'b0;
        end else if (active && fall) begin
            if (wrap) begin
                slot  <= '0;
                armed <= 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    always_comb begin
        cad.launch = active && fall && wrap;
        cad.miss   = active && fall && due && !ret_i;
        cad.extra  = active && fall && !due && ret_i;
    end
endmodule

// File: rtl/pstk_seq.sv
module pstk_seq
    import pstk_pkg::*;
#(
    parameter int MAX_PH = 8,
    parameter int LIMIT  = 16,
    parameter int PW     = 4,
    parameter int CW     = 5
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          fall,
    input  logic          ret_i,
    input  cadence_s      cad,
    output logic          token_o,
    output logic [PW-1:0] phase_cnt,
    output logic          fault,
    output logic          ready,
    output logic          restart,
    output logic          run_active
);
    seq_state_e    state;
    logic [CW-1:0] elapsed;
    logic          legal_now;

    assign legal_now  = count_ok(int'(elapsed), MAX_PH);
    assign restart    = fall && (state == ST_MEASURE) && ret_i && legal_now;
    assign run_active = (state == ST_RUN);
    assign ready      = (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (srst) begin
            state     <= ST_LAUNCH;
            elapsed   <= '0;
            phase_cnt <= '0;
            fault     <= 1'b0;
            token_o   <= 1'b0;
        end else if (fall) begin
            unique case (state)
                ST_LAUNCH: begin
                    token_o <= 1'b1;
                    elapsed <= '0;
                    state   <= ST_MEASURE;
                end
                ST_MEASURE: begin
                    token_o <= 1'b0;
                    if (ret_i) begin
                        if (legal_now) begin
                            phase_cnt <= elapsed[PW-1:0];
                            token_o   <= 1'b1;
                            state     <= ST_RUN;
                        end else begin
                            fault <= 1'b1;
                            state <= ST_FAULT;
                        end
                    end else if (elapsed == CW'(LIMIT - 1)) begin
                        fault <= 1'b1;
                        state <= ST_FAULT;
                    end else begin
                        elapsed <= elapsed + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (cad.miss || cad.extra) begin
                        fault   <= 1'b1;
                        token_o <= 1'b0;
                        state   <= ST_FAULT;
                    end else begin
                        token_o <= cad.launch;
                    end
                end
                default: begin
                    token_o <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pstk_token_seq.sv
module pstk_token_seq
    import pstk_pkg::*;
#(
    parameter int MAX_PHASES   = 8,
    parameter int SYS_DIV      = 4,
    parameter int RETURN_LIMIT = 16,
    localparam int PW = $clog2(MAX_PHASES + 1),
    localparam int CW = $clog2(RETURN_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          srst,
    input  logic          ring_ret_i,
    output logic          sysclk_o,
    output logic          token_o,
    output logic [PW-1:0] phase_cnt_o,
    output logic          ring_fault_o,
    output logic          ready_o
);
    sysclk_s  sc;
    cadence_s cad;
    logic     restart;
    logic     run_active;

    pstk_sysclk #(.SYS_DIV(SYS_DIV)) u_sysclk (
        .clk  (clk),
        .srst (srst),
        .sc   (sc)
    );

    pstk_cadence #(.PW(PW)) u_cadence (
        .clk     (clk),
        .srst    (srst),
        .fall    (sc.fall),
        .restart (restart),
        .active  (run_active),
        .period  (phase_cnt_o),
        .ret_i   (ring_ret_i),
        .cad     (cad)
    );

    pstk_seq #(
        .MAX_PH (MAX_PHASES),
        .LIMIT  (RETURN_LIMIT),
        .PW     (PW),
        .CW     (CW)
    ) u_seq (
        .clk        (clk),
        .srst       (srst),
        .fall       (sc.fall),
        .ret_i      (ring_ret_i),
        .cad        (cad),
        .token_o    (token_o),
        .phase_cnt  (phase_cnt_o),
        .fault      (ring_fault_o),
        .ready      (ready_o),
        .restart    (restart),
        .run_active (run_active)
    );

    assign sysclk_o = sc.lvl;
endmodule

// File: rtl/pstk_token_seq_chk.sv
module pstk_token_seq_chk #(
    parameter int MAX_PHASES = 8,
    parameter int PW         = 4
) (
    input logic          clk,
    input logic          srst,
    input logic          sysclk_o,
    input logic          token_o,
    input logic [PW-1:0] phase_cnt_o,
    input logic          ring_fault_o,
    input logic          ready_o
);
    // R9: fault holds until reset
    a_r9_fault_sticky: assert property (@(posedge clk) disable iff (srst)
        ring_fault_o |=> ring_fault_o);

    // R9: no token is driven into the ring while the fault is set
    a_r9_token_quiet: assert property (@(posedge clk) disable iff (srst)
        ring_fault_o |-> !token_o);

    // R8: ready and fault never overlap
    a_r8_ready_excl: assert property (@(posedge clk) disable iff (srst)
        ready_o |-> !ring_fault_o);

    // R4: a published count lies in the legal range and is held
    a_r4_count_legal: assert property (@(posedge clk) disable iff (srst)
        ready_o |-> (phase_cnt_o >= PW'(1) && phase_cnt_o <= PW'(MAX_PHASES)));

    a_r4_count_held: assert property (@(posedge clk) disable iff (srst)
        (ready_o && $past(ready_o)) |-> $stable(phase_cnt_o));

    // R3: the token only changes right after a fall of the system clock
    a_r3_token_on_fall: assert property (@(posedge clk) disable iff (srst)
        !$stable(token_o) |-> (!$past(sysclk_o) && $past(sysclk_o, 2)));
endmodule

bind pstk_token_seq pstk_token_seq_chk #(
    .MAX_PHASES (MAX_PHASES),
    .PW         (PW)
) u_chk (
    .clk          (clk),
    .srst         (srst),
    .sysclk_o     (sysclk_o),
    .token_o      (token_o),
    .phase_cnt_o  (phase_cnt_o),
    .ring_fault_o (ring_fault_o),
    .ready_o      (ready_o)
);

// File: tb/pstk_token_seq_tb.sv
module pstk_token_seq_tb;
    localparam int DIV   = 4;
    localparam int MAXP  = 8;
    localparam int LIM   = 16;
    localparam int RING  = 10;

    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic       ret;
    logic       sysclk_o, token_o, ring_fault_o, ready_o;
    logic [3:0] phase_cnt_o;
    logic [RING-1:0] st_o;
    int  sel = 1;
    logic brk = 1'b0;
    logic inj = 1'b0;

    int errors = 0;
    int checks = 0;
    int tick_no = 0;
    logic prev_clk = 1'b1;
    logic at_fall = 1'b0;
    int cyc = 0;

    always #5 clk = ~clk;

    pstk_token_seq u_dut (
        .clk          (clk),
        .srst         (srst),
        .ring_ret_i   (ret),
        .sysclk_o     (sysclk_o),
        .token_o      (token_o),
        .phase_cnt_o  (phase_cnt_o),
        .ring_fault_o (ring_fault_o),
        .ready_o      (ready_o)
    );

    for (genvar g = 0; g < RING; g++) begin : g_ring
        if (g == 0) begin : g_first
            pstk_phase_stage u_st (.clk(clk), .srst(srst), .sysclk_i(sysclk_o),
                                   .token_i(token_o), .token_o(st_o[0]));
        end else begin : g_next
            pstk_phase_stage u_st (.clk(clk), .srst(srst), .sysclk_i(sysclk_o),
                                   .token_i(st_o[g-1]), .token_o(st_o[g]));
        end
    end

    always_comb begin
        if (brk) ret = 1'b0;
        else if (sel == 0) ret = token_o | inj;
        else ret = st_o[sel-1] | inj;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=%0d expected<=150000", cyc);
            summary();
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        at_fall = prev_clk && !sysclk_o;
        if (at_fall) tick_no++;
        prev_clk = sysclk_o;
    endtask

    task automatic until_tick(input int k);
        while (tick_no < k) step();
    endtask

    task automatic do_reset();
        @(negedge clk);
        srst = 1'b1;
        repeat (3) @(negedge clk);
        chk(phase_cnt_o == 0 && !ring_fault_o && !ready_o && !token_o, "R1 in reset",
            {phase_cnt_o, ring_fault_o, ready_o, token_o}, 0);
        srst = 1'b0;
        tick_no = 0;
        prev_clk = 1'b1;
        step();
        chk(phase_cnt_o == 0 && !ring_fault_o && !ready_o && !token_o, "R1 after release",
            {phase_cnt_o, ring_fault_o, ready_o, token_o}, 0);
    endtask

    // Counts over a whole number of run periods
    task automatic run_window(input int n);
        int tok_hi = 0;
        int clk_hi = 0;
        int st_bad = 0;
        logic rec = 1'b0;
        logic pend = 1'b0;
        for (int i = 0; i < 4 * n * DIV; i++) begin
            step();
            if (pend) begin
                if (st_o[0] !== rec) st_bad++;
                pend = 1'b0;
            end
            if (at_fall) begin
                rec = token_o;
                pend = 1'b1;
            end
            if (token_o) tok_hi++;
            if (sysclk_o) clk_hi++;
        end
        chk(tok_hi == 4 * DIV, $sformatf("R7 token duty N=%0d", n), tok_hi, 4 * DIV);
        chk(clk_hi == 2 * n * DIV, $sformatf("R2 sysclk duty N=%0d", n), clk_hi, 2 * n * DIV);
        chk(st_bad == 0, "R10 stage capture", st_bad, 0);
        chk(!ring_fault_o && ready_o, $sformatf("R8 no false alarm N=%0d", n),
            ring_fault_o, 0);
    endtask

    initial begin
        // Sweep every ring length from 0 to 10
        for (int n = 0; n <= RING; n++) begin
            sel = n;
            brk = 1'b0;
            inj = 1'b0;
            do_reset();
            if (n >= 1) begin
                until_tick(1);
                chk(!token_o, "R3 token before launch", token_o, 0);
                step();
                chk(token_o, "R3 token launched", token_o, 1);
                until_tick(2);
                chk(token_o, "R3 token held one period", token_o, 1);
                step();
                chk(!token_o, "R3 token dropped", token_o, 0);
            end
            until_tick(n + 2);
            chk(!ready_o && !ring_fault_o, $sformatf("R4 before return N=%0d", n),
                {ready_o, ring_fault_o}, 0);
            step();
            if (n >= 1 && n <= MAXP) begin
                chk(ready_o && !ring_fault_o, $sformatf("R4 ready N=%0d", n), ready_o, 1);
                chk(phase_cnt_o == 4'(n), "R4 phase count", phase_cnt_o, n);
                run_window(n);
            end else begin
                chk(ring_fault_o && !ready_o, $sformatf("R5 illegal count N=%0d", n),
                    ring_fault_o, 1);
                chk(phase_cnt_o == 0, "R5 count stays zero", phase_cnt_o, 0);
            end
        end

        // R6: ring open from reset, fault at exactly fall 17
        sel = 3;
        brk = 1'b1;
        do_reset();
        until_tick(LIM + 1);
        chk(!ring_fault_o, "R6 no fault before limit", ring_fault_o, 0);
        step();
        chk(ring_fault_o && !ready_o, "R6 timeout fault", ring_fault_o, 1);

        // R8 + R9: break in steady run, then repair; fault stays, token quiet
        brk = 1'b0;
        sel = 3;
        do_reset();
        until_tick(5);
        step();
        chk(ready_o, "R4 ready before break", ready_o, 1);
        repeat (7 * DIV) step();
        brk = 1'b1;
        repeat (5 * DIV) step();
        chk(ring_fault_o && !ready_o, "R8 missing token fault", ring_fault_o, 1);
        brk = 1'b0;
        begin
            int hi = 0;
            for (int i = 0; i < 20 * DIV; i++) begin
                step();
                if (token_o) hi++;
            end
            chk(hi == 0, "R9 token silent in fault", hi, 0);
            chk(ring_fault_o, "R9 fault sticky", ring_fault_o, 1);
        end

        // R8: spurious token on the first fall after detection (N=4)
        sel = 4;
        do_reset();
        until_tick(6);
        step();
        chk(ready_o, "R4 ready before inject", ready_o, 1);
        inj = 1'b1;
        repeat (DIV) step();
        inj = 1'b0;
        step();
        chk(ring_fault_o && !ready_o, "R8 extra token fault", ring_fault_o, 1);

        // R1: reset clears the fault and detection is learned again
        sel = 2;
        do_reset();
        until_tick(4);
        step();
        chk(ready_o && phase_cnt_o == 2, "R1 relearn after reset", phase_cnt_o, 2);

        summary();
    end
endmodule